// File: doc/BRIEF.md
# DRAM ECC Scrub Command Sequencer

This block writes every location of the populated DRAM ranks once so that the stored ECC check bits agree with the data. After a start pulse it walks the ranks that are marked present, in ascending order. Inside each rank it covers every bank, and inside each bank it covers every row. For each row it emits one activate, then a fixed run of write bursts, then a precharge. The gap between commands comes from the DRAM timing values on its inputs, so one netlist serves any speed grade. Every write carries an all-zero data pattern.

Firmware programs the timing inputs, the row-address width and the rank-presence mask before it pulses start. It then waits for done. When ECC is enabled, the block first holds off for a settle time of STARTUP_CYC cycles, 10 µs at the target clock, and only then issues the first command. The command outputs are meant for a PHY command path. The write-data strobe marks the cycles that carry a write.

Top module: `ecc_scrub_seq`

## Requirements
- R1: After reset, and whenever busy_o is low, cmd_o is NOP (encoding NOP=0, ACT=1, WR=2, PRE=3), done_o is 0 until the first run completes, and wdata_vld_o is 0.
- R2: Commands cover each rank whose bit is set in rank_mask_i, in ascending rank order. Within a rank they cover banks 0 to NUM_BANKS-1 in order, and within a bank they cover rows 0 to 2^rb-1 in order, where rb is row_bits_i clamped to the range [4, MAX_ROW_BITS]. A rank whose mask bit is clear receives no command.
- R3: Each row receives one ACT with cmd_addr_o equal to the row, then WR_COUNT WR commands, then one PRE with cmd_addr_o equal to 0, all on the same rank and bank.
- R4: The first WR of a row comes max((t_faw_i >> 2) + 1, t_rrd_i) + t_rcd_i cycles after its ACT.
- R5: Consecutive WR commands of a row are exactly 4 cycles apart.
- R6: The k-th WR of a row (k counted from 0) carries column address (8·k) mod 512 in cmd_addr_o[8:0]; all higher address bits are 0.
- R7: The PRE comes t_wtr_i + t_cwl_i + 8 cycles after the last WR of its row.
- R8: The next ACT comes 4 + t_rp_i cycles after a PRE.
- R9: wdata_vld_o is high exactly in the cycles that carry a WR, and wdata_o is always all zeros.
- R10: If start_i is sampled high at a clock edge while the block is idle, busy_o is high from the next cycle. The first ACT appears in that next cycle when ecc_en_i is 0, and STARTUP_CYC cycles later when ecc_en_i is 1.
- R11: done_o rises 4 + t_rp_i + 1 cycles after the final PRE, together with busy_o falling. done_o stays high until the next start, and a start with an all-zero mask goes straight to done with no command.
- R12: A start_i pulse while busy_o is high does not change the command stream or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| ecc_en_i | input | 1 | Apply the settle delay before the first command |
| rank_mask_i | input | NUM_RANKS | Rank present bits |
| row_bits_i | input | $clog2(MAX_ROW_BITS+1) | Number of row address bits |
| t_rcd_i | input | TW | Activate-to-write delay, in cycles |
| t_rp_i | input | TW | Precharge time, in cycles |
| t_rrd_i | input | TW | Activate-to-activate spacing, in cycles |
| t_faw_i | input | TW | Four-activate window, in cycles |
| t_wtr_i | input | TW | Write-to-read turnaround, in cycles |
| t_cwl_i | input | TW | Write latency, in cycles |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished |
| cmd_o | output | 2 | Command code |
| cmd_rank_o | output | $clog2(NUM_RANKS) | Command rank |
| cmd_bank_o | output | $clog2(NUM_BANKS) | Command bank |
| cmd_addr_o | output | MAX_ROW_BITS | Row address for ACT, column address for WR, 0 for PRE |
| wdata_vld_o | output | 1 | Write data valid |
| wdata_o | output | DATA_W | Write data, always zero |

## Verification
Three things can fall in the same cycle. The precharge wait of the last row of a bank expires, the bank counter rolls over, and the next populated rank is chosen. The next ACT must come in that very cycle and name a rank further on, which may mean skipping empty ranks. Rank masks with holes (0100, 1001) make this happen at every bank and rank boundary. Each case is judged by comparing the rank, bank, row and inter-command delay of every command with a model in the bench. In the same runs, a second start pulse lands while the sequence is running and the column counter wraps in the middle of a row's write run. Both must leave the stream identical to the model's.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_ACT = 2'd0,
        PH_WR  = 2'd1,
        PH_PRE = 2'd2,
        PH_FIN = 2'd3
    } seq_ph_e;
endpackage

// File: rtl/scrub_gap_calc.sv
module scrub_gap_calc #(
    parameter int TW        = 6,
    parameter int GW        = 9,
    parameter int PRE_GAP   = 4,
    parameter int WTR_EXTRA = 8
) (
    input  logic [TW-1:0] t_rcd_i,
    input  logic [TW-1:0] t_rp_i,
    input  logic [TW-1:0] t_rrd_i,
    input  logic [TW-1:0] t_faw_i,
    input  logic [TW-1:0] t_wtr_i,
    input  logic [TW-1:0] t_cwl_i,
    output logic [GW-1:0] act_dly_o,
    output logic [GW-1:0] wr_tail_o,
    output logic [GW-1:0] pre_dly_o
);
    logic [GW-1:0] faw_share;
    logic [GW-1:0] rrd_ext;
    logic [GW-1:0] act_space;

    always_comb begin
        // a quarter of the four-activate window, rounded up by one
        faw_share = GW'(t_faw_i >> 2) + GW'(1);
        rrd_ext   = GW'(t_rrd_i);
        act_space = (faw_share > rrd_ext) ? faw_share : rrd_ext;
        act_dly_o = act_space + GW'(t_rcd_i);
        wr_tail_o = GW'(t_wtr_i) + GW'(t_cwl_i) + GW'(WTR_EXTRA);
        pre_dly_o = GW'(PRE_GAP) + GW'(t_rp_i);
    end
endmodule

// File: rtl/scrub_rank_pick.sv
module scrub_rank_pick #(
    parameter int NUM_RANKS = 4,
    parameter int RW        = 2,
    parameter int RIW       = 3
) (
    input  logic [NUM_RANKS-1:0] mask_i,
    input  logic [RIW-1:0]       from_i,
    output logic                 found_o,
    output logic [RW-1:0]        idx_o
);
    logic [NUM_RANKS-1:0] cand;

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cand
        assign cand[g] = mask_i[g] && (RIW'(g) >= from_i);
    end

    always_comb begin
        found_o = |cand;
        idx_o   = '0;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx_o = RW'(i);
            end
        end
    end
endmodule

// File: rtl/scrub_wait_timer.sv
module scrub_wait_timer #(
    parameter int TMW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [TMW-1:0] val_i,
    output logic           expired_o
);
    logic [TMW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TMW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ecc_scrub_seq.sv
module ecc_scrub_seq
    import scrub_pkg::*;
#(
    parameter int NUM_RANKS    = 4,
    parameter int NUM_BANKS    = 8,
    parameter int MAX_ROW_BITS = 16,
    parameter int MIN_ROW_BITS = 4,
    parameter int TW           = 6,
    parameter int DATA_W       = 64,
    parameter int WR_COUNT     = 129,
    parameter int COL_BITS     = 9,
    parameter int COL_STEP     = 8,
    parameter int WR_GAP       = 4,
    parameter int PRE_GAP      = 4,
    parameter int WTR_EXTRA    = 8,
    parameter int STARTUP_CYC  = 1000,
    localparam int RW  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int RBW = $clog2(MAX_ROW_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    ecc_en_i,
    input  logic [NUM_RANKS-1:0]    rank_mask_i,
    input  logic [RBW-1:0]          row_bits_i,
    input  logic [TW-1:0]           t_rcd_i,
    input  logic [TW-1:0]           t_rp_i,
    input  logic [TW-1:0]           t_rrd_i,
    input  logic [TW-1:0]           t_faw_i,
    input  logic [TW-1:0]           t_wtr_i,
    input  logic [TW-1:0]           t_cwl_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [1:0]              cmd_o,
    output logic [RW-1:0]           cmd_rank_o,
    output logic [BW-1:0]           cmd_bank_o,
    output logic [MAX_ROW_BITS-1:0] cmd_addr_o,
    output logic                    wdata_vld_o,
    output logic [DATA_W-1:0]       wdata_o
);
    localparam int RIW  = $clog2(NUM_RANKS + 1);
    localparam int ROWW = MAX_ROW_BITS;
    localparam int WCW  = (WR_COUNT > 1) ? $clog2(WR_COUNT) : 1;
    localparam int GW   = TW + 3;
    localparam int SUW  = $clog2(STARTUP_CYC + 1);
    localparam int TMW  = (SUW > GW) ? SUW : GW;

    typedef struct packed {
        seq_st_e         st;
        seq_ph_e         ph;
        logic [RW-1:0]   rank;
        logic [BW-1:0]   bank;
        logic [ROWW-1:0] row;
        logic [WCW-1:0]  widx;
        logic [COL_BITS-1:0] col;
        logic            done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [GW-1:0]  act_dly, wr_tail, pre_dly;
    logic           first_found, next_found;
    logic [RW-1:0]  first_idx, next_idx;
    logic           tmr_load, tmr_expired;
    logic [TMW-1:0] tmr_val;
    logic [RBW-1:0] rb_eff;
    logic [ROWW-1:0] row_max;
    logic [RIW-1:0] next_from;

    scrub_gap_calc #(
        .TW(TW), .GW(GW), .PRE_GAP(PRE_GAP), .WTR_EXTRA(WTR_EXTRA)
    ) u_gap (
        .t_rcd_i(t_rcd_i), .t_rp_i(t_rp_i), .t_rrd_i(t_rrd_i),
        .t_faw_i(t_faw_i), .t_wtr_i(t_wtr_i), .t_cwl_i(t_cwl_i),
        .act_dly_o(act_dly), .wr_tail_o(wr_tail), .pre_dly_o(pre_dly)
    );

    scrub_rank_pick #(
        .NUM_RANKS(NUM_RANKS), .RW(RW), .RIW(RIW)
    ) u_first (
        .mask_i(rank_mask_i), .from_i('0),
        .found_o(first_found), .idx_o(first_idx)
    );

    assign next_from = RIW'(s_q.rank) + RIW'(1);

    scrub_rank_pick #(
        .NUM_RANKS(NUM_RANKS), .RW(RW), .RIW(RIW)
    ) u_next (
        .mask_i(rank_mask_i), .from_i(next_from),
        .found_o(next_found), .idx_o(next_idx)
    );

    scrub_wait_timer #(
        .TMW(TMW)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .val_i(tmr_val),
        .expired_o(tmr_expired)
    );

    // clamp the row width into the supported range
    always_comb begin
        if (row_bits_i < RBW'(MIN_ROW_BITS)) begin
            rb_eff = RBW'(MIN_ROW_BITS);
        end else if (row_bits_i > RBW'(MAX_ROW_BITS)) begin
            rb_eff = RBW'(MAX_ROW_BITS);
        end else begin
            rb_eff = row_bits_i;
        end
        row_max = {ROWW{1'b1}} >> (ROWW - int'(rb_eff));
    end

    always_comb begin
        s_d         = s_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        cmd_o       = CMD_NOP;
        cmd_rank_o  = s_q.rank;
        cmd_bank_o  = s_q.bank;
        cmd_addr_o  = '0;
        wdata_vld_o = 1'b0;

        unique case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    if (first_found) begin
                        s_d.st   = ST_RUN;
                        s_d.ph   = PH_ACT;
                        s_d.rank = first_idx;
                        s_d.bank = '0;
                        s_d.row  = '0;
                        s_d.done = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = ecc_en_i ? TMW'(STARTUP_CYC) : '0;
                    end else begin
                        s_d.st   = ST_DONE;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (tmr_expired) begin
                    unique case (s_q.ph)
                        PH_ACT: begin
                            cmd_o      = CMD_ACT;
                            cmd_addr_o = s_q.row;
                            tmr_load   = 1'b1;
                            tmr_val    = TMW'(act_dly) - TMW'(1);
                            s_d.ph     = PH_WR;
                            s_d.widx   = '0;
                            s_d.col    = '0;
                        end
                        PH_WR: begin
                            cmd_o       = CMD_WR;
                            cmd_addr_o  = ROWW'(s_q.col);
                            wdata_vld_o = 1'b1;
                            tmr_load    = 1'b1;
                            s_d.col     = s_q.col + COL_BITS'(COL_STEP);
                            if (s_q.widx == WCW'(WR_COUNT - 1)) begin
                                tmr_val = TMW'(wr_tail) - TMW'(1);
                                s_d.ph  = PH_PRE;
                            end else begin
                                tmr_val  = TMW'(WR_GAP - 1);
                                s_d.widx = s_q.widx + WCW'(1);
                            end
                        end
                        PH_PRE: begin
                            cmd_o      = CMD_PRE;
                            cmd_addr_o = '0;
                            tmr_load   = 1'b1;
                            tmr_val    = TMW'(pre_dly) - TMW'(1);
                            s_d.ph     = PH_ACT;
                            if (s_q.row == row_max) begin
                                s_d.row = '0;
                                if (s_q.bank == BW'(NUM_BANKS - 1)) begin
                                    s_d.bank = '0;
                                    if (next_found) begin
                                        s_d.rank = next_idx;
                                    end else begin
                                        s_d.ph = PH_FIN;
                                    end
                                end else begin
                                    s_d.bank = s_q.bank + BW'(1);
                                end
                            end else begin
                                s_d.row = s_q.row + ROWW'(1);
                            end
                        end
                        PH_FIN: begin
                            s_d.st   = ST_DONE;
                            s_d.done = 1'b1;
                        end
                        default: s_d.ph = PH_ACT;
                    endcase
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ph: PH_ACT, rank: '0, bank: '0, row: '0,
                     widx: '0, col: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.st == ST_RUN);
    assign done_o  = s_q.done;
    assign wdata_o = '0;
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk #(
    parameter int NUM_RANKS = 4,
    parameter int RW        = 2,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RANKS-1:0] rank_mask_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [1:0]           cmd_o,
    input logic [RW-1:0]        cmd_rank_o,
    input logic [ADDR_W-1:0]    cmd_addr_o,
    input logic                 wdata_vld_o,
    input logic [DATA_W-1:0]    wdata_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cmd_o == 2'd0 && !wdata_vld_o));

    // R2
    rank_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd0) |-> rank_mask_i[cmd_rank_o]);

    // R3
    pre_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd3) |-> (cmd_addr_o == '0));

    // R5
    write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd2) |=> (cmd_o == 2'd0));

    // R9
    wdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_vld_o |-> (wdata_o == '0 && cmd_o == 2'd2));

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == 2'd0 && !busy_o));
endmodule

bind ecc_scrub_seq scrub_seq_chk #(
    .NUM_RANKS(NUM_RANKS), .RW(RW), .ADDR_W(MAX_ROW_BITS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rank_mask_i(rank_mask_i),
    .busy_o(busy_o), .done_o(done_o), .cmd_o(cmd_o),
    .cmd_rank_o(cmd_rank_o), .cmd_addr_o(cmd_addr_o),
    .wdata_vld_o(wdata_vld_o), .wdata_o(wdata_o)
);

// File: tb/sim_ecc_scrub_seq.sv
module sim_ecc_scrub_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NR    = 4;
    localparam int NB    = 8;
    localparam int MAXRB = 12;
    localparam int RBW   = $clog2(MAXRB + 1);
    localparam int TW    = 6;
    localparam int WRC   = 66;
    localparam int SC    = 40;
    localparam int WDOG  = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ecc_en = 1'b0;
    logic [NR-1:0] mask = '0;
    logic [RBW-1:0] rbits = '0;
    logic [TW-1:0] t_rcd = 6'd5, t_rp = 6'd5, t_rrd = 6'd2;
    logic [TW-1:0] t_faw = 6'd16, t_wtr = 6'd4, t_cwl = 6'd5;
    logic busy, done, wvld;
    logic [1:0] cmd;
    logic [1:0] crank;
    logic [2:0] cbank;
    logic [MAXRB-1:0] caddr;
    logic [63:0] wdata;

    ecc_scrub_seq #(
        .NUM_RANKS(NR), .NUM_BANKS(NB), .MAX_ROW_BITS(MAXRB), .TW(TW),
        .WR_COUNT(WRC), .STARTUP_CYC(SC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ecc_en_i(ecc_en),
        .rank_mask_i(mask), .row_bits_i(rbits),
        .t_rcd_i(t_rcd), .t_rp_i(t_rp), .t_rrd_i(t_rrd), .t_faw_i(t_faw),
        .t_wtr_i(t_wtr), .t_cwl_i(t_cwl),
        .busy_o(busy), .done_o(done), .cmd_o(cmd), .cmd_rank_o(crank),
        .cmd_bank_o(cbank), .cmd_addr_o(caddr), .wdata_vld_o(wvld),
        .wdata_o(wdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // reference model state
    bit    mon_on = 1'b0;
    bit    e_fin = 1'b1;
    bit    e_empty = 1'b0;
    int    e_rank, e_bank, e_row, e_ph, e_wi, e_gap, last_cyc, fin_cyc;
    string e_tag;

    function automatic int act_gap();
        int q = (int'(t_faw) >> 2) + 1;
        int r = int'(t_rrd);
        return ((q > r) ? q : r) + int'(t_rcd);
    endfunction

    function automatic int wr_tail();
        return int'(t_wtr) + int'(t_cwl) + 8;
    endfunction

    function automatic int pre_gap();
        return 4 + int'(t_rp);
    endfunction

    function automatic int n_rows();
        int rb = int'(rbits);
        if (rb < 4) rb = 4;
        if (rb > MAXRB) rb = MAXRB;
        return 1 << rb;
    endfunction

    function automatic int rank_next(input int from);
        for (int r = from; r < NR; r++) begin
            if (mask[r]) return r;
        end
        return -1;
    endfunction

    function automatic int exp_addr();
        if (e_ph == 0) return e_row;
        if (e_ph == 1) return (e_wi * 8) % 512;
        return 0;
    endfunction

    task automatic model_step();
        case (e_ph)
            0: begin e_gap = act_gap(); e_tag = "R4"; e_ph = 1; e_wi = 0; end
            1: begin
                if (e_wi == WRC - 1) begin
                    e_gap = wr_tail(); e_tag = "R7"; e_ph = 2;
                end else begin
                    e_gap = 4; e_tag = "R5"; e_wi++;
                end
            end
            default: begin
                e_gap = pre_gap(); e_tag = "R8"; e_ph = 0;
                if (e_row == n_rows() - 1) begin
                    e_row = 0;
                    if (e_bank == NB - 1) begin
                        int nr;
                        e_bank = 0;
                        nr = rank_next(e_rank + 1);
                        if (nr < 0) begin
                            e_fin = 1'b1;
                            fin_cyc = cyc + e_gap + 1;
                        end else begin
                            e_rank = nr;
                        end
                    end else begin
                        e_bank++;
                    end
                end else begin
                    e_row++;
                end
            end
        endcase
        last_cyc = cyc;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (cmd != 2'd0) begin
                if (e_fin) begin
                    chk(1'b0, "R2 command after the last row", cmd, 0);
                end else begin
                    chk(cmd == 2'(e_ph + 1), "R3 command kind", cmd, e_ph + 1);
                    chk(crank == 2'(e_rank), "R2 rank", crank, e_rank);
                    chk(cbank == 3'(e_bank), "R2 bank", cbank, e_bank);
                    chk(int'(caddr) == exp_addr(), (e_ph == 1) ? "R6 column" : "R3 address",
                        caddr, exp_addr());
                    chk(cyc - last_cyc == e_gap, e_tag, cyc - last_cyc, e_gap);
                    chk(wvld == (cmd == 2'd2) && wdata == 64'd0, "R9 data strobe",
                        wvld, cmd == 2'd2);
                    model_step();
                end
            end else if (wvld) begin
                chk(1'b0, "R9 strobe without write", 1, 0);
            end
            if (e_fin && !e_empty && cyc == fin_cyc - 1) begin
                chk(done == 1'b0, "R11 done early", done, 0);
            end
            if (e_fin && cyc == fin_cyc) begin
                chk(done && !busy, "R11 done timing", {done, busy}, 2);
            end
        end
    end

    task automatic run_scrub(input logic [NR-1:0] m, input int rb, input bit ecc,
                             input bit poke_busy);
        @(negedge clk);
        mask = m;
        rbits = RBW'(rb);
        ecc_en = ecc;
        e_bank = 0; e_row = 0; e_ph = 0; e_wi = 0; e_gap = 0;
        e_rank = rank_next(0);
        e_tag = "R10";
        if (e_rank < 0) begin
            e_fin = 1'b1; e_empty = 1'b1; fin_cyc = cyc + 1;
        end else begin
            e_fin = 1'b0; e_empty = 1'b0;
            last_cyc = cyc + 1 + (ecc ? SC : 0);
        end
        start = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!e_empty) begin
            chk(busy && !done, "R10 busy after start", {busy, done}, 2);
        end else begin
            chk(done && !busy, "R11 empty mask done", {done, busy}, 2);
        end
        if (poke_busy) begin
            repeat (700) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(busy && !done, "R12 start while busy", {busy, done}, 2);
        end
        while (!(e_fin && cyc >= fin_cyc + 2)) @(negedge clk);
        chk(cmd == 2'd0 && done, "R11 done holds", {cmd, done}, 1);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        chk(1'b0, "watchdog", cyc, WDOG);
        wrap_up();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5C2B_17E3);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd == 2'd0 && !done && !busy && !wvld, "R1 reset state",
            {cmd, done, busy, wvld}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd == 2'd0 && !done && !busy, "R1 idle after reset", {cmd, done, busy}, 0);

        // random timing, four-activate window dominant, one rank with gaps below it
        t_rcd = TW'($urandom_range(15, 5));
        t_rp  = TW'($urandom_range(15, 5));
        t_rrd = TW'($urandom_range(4, 1));
        t_faw = TW'($urandom_range(40, 20));
        t_wtr = TW'($urandom_range(8, 2));
        t_cwl = TW'($urandom_range(10, 5));
        run_scrub(4'b0100, 2, 1'b1, 1'b1);

        // directed: activate spacing dominant, minimum waits, two ranks with a hole
        t_rcd = 6'd2; t_rp = 6'd0; t_rrd = 6'd6; t_faw = 6'd8;
        t_wtr = 6'd1; t_cwl = 6'd0;
        run_scrub(4'b1001, 4, 1'b0, 1'b0);

        // empty mask
        run_scrub(4'b0000, 6, 1'b1, 1'b0);

        wrap_up();
    end
endmodule